// File: doc/BRIEF.md
# Clock Supervisor with RC Frequency Meter

This block watches three clocks from the domain of an always-running internal RC clock, which also clocks its register port. It supervises a PLL-derived clock against a programmable frequency window: it counts PLL edges over a fixed number of crystal cycles and compares each count with a high and a low limit. It also flags a stalled crystal, with a timeout scaled by a software-set divider. A separate one-shot meter measures the RC clock against the crystal. It counts crystal cycles over a programmed number of RC cycles. Software then derives the RC frequency as F_rc = F_xtal × DUR / RESULT.

Each clock-domain crossing carries a free-running Gray-coded counter through a two-flop synchronizer. All window and meter arithmetic is done on differences of synchronized counts in the RC domain. Fault events leave as one-cycle pulses toward a fault collector and also set sticky status bits.

Top module: `ckmon_top`

## Requirements
- R1: After reset, every readable register (addresses 0..4) reads zero and all three fault pulses are low.
- R2: Writing address 0 with bit 1 set starts a measurement. Bit 1 reads 1 while it runs and is cleared by hardware exactly max(DUR,1) RC cycles after the accepting edge. DUR is the 20-bit value at address 3.
- R3: At the end of a measurement, the crystal cycle count seen during the window (within ±2) is loaded into the result register at address 4.
- R4: A start write during a running measurement neither restarts nor extends it. The result register keeps its old value until the new count is loaded.
- R5: With supervision enabled (address 0 bit 0), a window whose PLL edge count exceeds the high limit (address 1) pulses `fault_hi_o` and sets sticky bit 8.
- R6: With supervision enabled, a window count below the low limit (address 2) pulses `fault_lo_o` and sets sticky bit 9.
- R7: A PLL count within [low, high] raises no frequency fault.
- R8: With bit 0 clear, no fault pulse is raised and no sticky bit is set, whatever the PLL frequency.
- R9: With supervision enabled, no crystal activity for 16 << DIV RC cycles pulses `fault_xloss_o` once per stall and sets sticky bit 10. DIV is address 0 bits 3:2.
- R10: Sticky bits 8..10 clear when written with 1. Writing 0 to them leaves them unchanged. A new fault in the same cycle wins over the clear.
- R11: Every fault pulse lasts exactly one RC cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Internal RC clock; clocks the register port and all decisions |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| xtal_clk | input | 1 | Crystal reference clock |
| pll_clk | input | 1 | Supervised PLL clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control/status, 1 high, 2 low, 3 duration, 4 result) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| fault_hi_o | output | 1 | One-cycle pulse: PLL above high limit |
| fault_lo_o | output | 1 | One-cycle pulse: PLL below low limit |
| fault_xloss_o | output | 1 | One-cycle pulse: crystal stalled |

## Verification
The bench builds the block with a 24-bit count width, a 32-crystal-cycle supervision window and a stall base of 16 RC cycles. With these values a whole window takes tens of RC cycles, so random window limits, several PLL periods and a full crystal stall each fit inside a few hundred cycles. The small stall base also keeps the largest divider setting short enough to confirm the one-pulse-per-stall rule and the boundary on either side of the timeout.

// File: rtl/ckmon_pkg.sv
`timescale 1ns/1ps
package ckmon_pkg;
  localparam int ADDR_W = 3;
  localparam int DUR_W  = 20;
  localparam int DIV_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_HIGH = 3'd1,
    A_LOW  = 3'd2,
    A_DUR  = 3'd3,
    A_RES  = 3'd4
  } reg_addr_e;

  localparam int B_EN     = 0;
  localparam int B_GO     = 1;
  localparam int B_DIV    = 2;
  localparam int B_HI     = 8;
  localparam int B_LO     = 9;
  localparam int B_LOSS   = 10;
endpackage

// File: rtl/ckmon_cnt_xfer.sv
`timescale 1ns/1ps
module ckmon_cnt_xfer #(
  parameter int W = 24
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst_n,
  output logic [W-1:0] dst_bin
);
  logic [W-1:0] bin_q, gray_q, sync1_q, sync2_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_q + 1'b1;
      gray_q <= bin_q ^ (bin_q >> 1);
    end
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= gray_q;
      sync2_q <= sync1_q;
    end
  end

  function automatic logic [W-1:0] g2b(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign dst_bin = g2b(sync2_q);
endmodule

// File: rtl/ckmon_meter.sv
`timescale 1ns/1ps
module ckmon_meter #(
  parameter int CNT_W = 24,
  parameter int DUR_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic [CNT_W-1:0] xbin_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] result_o
);
  logic [DUR_W-1:0] left_q;
  logic [CNT_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      left_q   <= '0;
      base_q   <= '0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          left_q <= (dur_i == '0) ? DUR_W'(1) : dur_i;
          base_q <= xbin_i;
        end
      end else begin
        left_q <= left_q - 1'b1;
        if (left_q == DUR_W'(1)) begin
          busy_o   <= 1'b0;
          done_o   <= 1'b1;
          result_o <= xbin_i - base_q;
        end
      end
    end
  end

  a_r2_end_marks_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
endmodule

// File: rtl/ckmon_super.sv
`timescale 1ns/1ps
module ckmon_super #(
  parameter int CNT_W     = 24,
  parameter int WIN_REF   = 256,
  parameter int LOSS_BASE = 16,
  parameter int DIV_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CNT_W-1:0] high_i,
  input  logic [CNT_W-1:0] low_i,
  input  logic [CNT_W-1:0] xbin_i,
  input  logic [CNT_W-1:0] pbin_i,
  output logic             hi_o,
  output logic             lo_o,
  output logic             loss_o
);
  localparam int LMAX = LOSS_BASE << ((1 << DIV_W) - 1);
  localparam int LCW  = $clog2(LMAX + 1);

  logic [CNT_W-1:0] xw0_q, pw0_q, xprev_q, xspan, pspan;
  logic [LCW-1:0]   lctr_q, limit;

  assign limit = LCW'(LOSS_BASE) << div_i;
  assign xspan = xbin_i - xw0_q;
  assign pspan = pbin_i - pw0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xw0_q   <= '0;
      pw0_q   <= '0;
      xprev_q <= '0;
      lctr_q  <= '0;
      hi_o    <= 1'b0;
      lo_o    <= 1'b0;
      loss_o  <= 1'b0;
    end else begin
      hi_o    <= 1'b0;
      lo_o    <= 1'b0;
      loss_o  <= 1'b0;
      xprev_q <= xbin_i;
      if (!en_i) begin
        xw0_q  <= xbin_i;
        pw0_q  <= pbin_i;
        lctr_q <= '0;
      end else begin
        if (xspan >= CNT_W'(WIN_REF)) begin
          hi_o  <= pspan > high_i;
          lo_o  <= pspan < low_i;
          xw0_q <= xbin_i;
          pw0_q <= pbin_i;
        end
        if (xbin_i != xprev_q) begin
          lctr_q <= '0;
        end else if (lctr_q < limit) begin
          lctr_q <= lctr_q + 1'b1;
          if (lctr_q == limit - 1'b1) loss_o <= 1'b1;
        end
      end
    end
  end

  a_r11_loss_single: assert property (@(posedge clk) disable iff (!rst_n)
    loss_o |=> !loss_o);
  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !$past(en_i)) |-> (!hi_o && !lo_o && !loss_o));
endmodule

// File: rtl/ckmon_top.sv
`timescale 1ns/1ps
module ckmon_top
  import ckmon_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int WIN_REF   = 256,
  parameter int LOSS_BASE = 16
) (
  input  logic        rc_clk,
  input  logic        rst_n,
  input  logic        xtal_clk,
  input  logic        pll_clk,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        fault_hi_o,
  output logic        fault_lo_o,
  output logic        fault_xloss_o
);
  logic [CNT_W-1:0] xbin, pbin, high_q, low_q, result;
  logic [DUR_W-1:0] dur_q;
  logic [DIV_W-1:0] div_q;
  logic             en_q, hi_st, lo_st, loss_st, busy, done;
  logic             wr_ctrl, go_req;
  logic [31:0]      ctrl_word;
  logic             unused_ok;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign go_req  = wr_ctrl && reg_wdata[B_GO];
  assign unused_ok = ^{reg_wdata, done};

  ckmon_cnt_xfer #(.W(CNT_W)) u_xcnt (
    .src_clk(xtal_clk), .dst_clk(rc_clk), .rst_n(rst_n), .dst_bin(xbin));
  ckmon_cnt_xfer #(.W(CNT_W)) u_pcnt (
    .src_clk(pll_clk), .dst_clk(rc_clk), .rst_n(rst_n), .dst_bin(pbin));

  ckmon_meter #(.CNT_W(CNT_W), .DUR_W(DUR_W)) u_meter (
    .clk(rc_clk), .rst_n(rst_n), .start_i(go_req), .dur_i(dur_q),
    .xbin_i(xbin), .busy_o(busy), .done_o(done), .result_o(result));

  ckmon_super #(.CNT_W(CNT_W), .WIN_REF(WIN_REF), .LOSS_BASE(LOSS_BASE),
                .DIV_W(DIV_W)) u_super (
    .clk(rc_clk), .rst_n(rst_n), .en_i(en_q), .div_i(div_q),
    .high_i(high_q), .low_i(low_q), .xbin_i(xbin), .pbin_i(pbin),
    .hi_o(fault_hi_o), .lo_o(fault_lo_o), .loss_o(fault_xloss_o));

  always_ff @(posedge rc_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      div_q   <= '0;
      high_q  <= '0;
      low_q   <= '0;
      dur_q   <= '0;
      hi_st   <= 1'b0;
      lo_st   <= 1'b0;
      loss_st <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata[B_EN];
        div_q <= reg_wdata[B_DIV +: DIV_W];
      end
      if (reg_wr && reg_addr == A_HIGH) high_q <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_addr == A_LOW)  low_q  <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_addr == A_DUR)  dur_q  <= reg_wdata[DUR_W-1:0];
      if (fault_hi_o)                           hi_st <= 1'b1;
      else if (wr_ctrl && reg_wdata[B_HI])      hi_st <= 1'b0;
      if (fault_lo_o)                           lo_st <= 1'b1;
      else if (wr_ctrl && reg_wdata[B_LO])      lo_st <= 1'b0;
      if (fault_xloss_o)                        loss_st <= 1'b1;
      else if (wr_ctrl && reg_wdata[B_LOSS])    loss_st <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word                  = '0;
    ctrl_word[B_EN]            = en_q;
    ctrl_word[B_GO]            = busy;
    ctrl_word[B_DIV +: DIV_W]  = div_q;
    ctrl_word[B_HI]            = hi_st;
    ctrl_word[B_LO]            = lo_st;
    ctrl_word[B_LOSS]          = loss_st;
  end

  always_comb begin
    case (reg_addr_e'(reg_addr))
      A_CTRL:  reg_rdata = ctrl_word;
      A_HIGH:  reg_rdata = 32'(high_q);
      A_LOW:   reg_rdata = 32'(low_q);
      A_DUR:   reg_rdata = 32'(dur_q);
      A_RES:   reg_rdata = 32'(result);
      default: reg_rdata = '0;
    endcase
  end

  a_r5_hi_sticky: assert property (@(posedge rc_clk) disable iff (!rst_n)
    fault_hi_o |=> hi_st);
  a_r6_lo_sticky: assert property (@(posedge rc_clk) disable iff (!rst_n)
    fault_lo_o |=> lo_st);
  a_r9_loss_sticky: assert property (@(posedge rc_clk) disable iff (!rst_n)
    fault_xloss_o |=> loss_st);
  a_r10_w1c_clears: assert property (@(posedge rc_clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[B_HI] && !fault_hi_o) |=> !hi_st);
endmodule

// File: tb/test_ckmon_top.sv
`timescale 1ns/1ps
module test_ckmon_top;
  logic        rc_clk = 1'b0, xtal_clk = 1'b0, pll_clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fault_hi_o, fault_lo_o, fault_xloss_o;

  real x_half = 5.0;
  real p_half = 2.0;
  bit  x_run  = 1'b1;
  int  n_run = 0, n_fail = 0;
  int  cyc = 0;
  int  pul_hi = 0, pul_lo = 0, pul_loss = 0, wide = 0;
  logic ph_hi = 0, ph_lo = 0, ph_loss = 0;

  ckmon_top #(.CNT_W(24), .WIN_REF(32), .LOSS_BASE(16)) i_ckmon_top (
    .rc_clk(rc_clk), .rst_n(rst_n), .xtal_clk(xtal_clk), .pll_clk(pll_clk),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fault_hi_o(fault_hi_o), .fault_lo_o(fault_lo_o),
    .fault_xloss_o(fault_xloss_o));

  initial forever #2.5 rc_clk = ~rc_clk;
  initial forever begin #(x_half); if (x_run) xtal_clk = ~xtal_clk; end
  initial forever begin #(p_half); pll_clk = ~pll_clk; end
  always @(posedge rc_clk) cyc++;

  always @(negedge rc_clk) begin
    if (fault_hi_o) pul_hi++;
    if (fault_lo_o) pul_lo++;
    if (fault_xloss_o) pul_loss++;
    if ((fault_hi_o && ph_hi) || (fault_lo_o && ph_lo) || (fault_xloss_o && ph_loss)) wide++;
    ph_hi = fault_hi_o; ph_lo = fault_lo_o; ph_loss = fault_xloss_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge rc_clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
    @(negedge rc_clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge rc_clk);
    reg_addr = 3'(a);
    #0.5;
    d = int'(reg_rdata);
  endtask

  function automatic int absdiff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic measure(input int md, input string tag);
    int c0, v, res, e, want;
    wr(3, md);
    wr(0, 32'h2);
    c0 = cyc;
    v = 2;
    while (v[1]) begin
      rd(0, v);
    end
    want = (md == 0) ? 1 : md;
    chk((cyc - c0) == want, {"R2 duration ", tag}, cyc - c0, want);
    rd(4, res);
    e = int'((real'(want) * 5.0) / (2.0 * x_half));
    chk(absdiff(res, e) <= 2, {"R3 result ", tag}, res, e);
  endtask

  task automatic window_case(input int ph, input int lo, input int hi);
    int e, st, h0, l0;
    bit eh, el, en;
    e  = 160 / ph;
    eh = e > hi + 4;
    el = e < lo - 4;
    en = (e >= lo + 4) && (e <= hi - 4);
    if (!(eh || el || en)) return;
    wr(1, hi); wr(2, lo);
    wr(0, 32'h700);
    p_half = real'(ph);
    repeat (20) @(negedge rc_clk);
    h0 = pul_hi; l0 = pul_lo;
    wr(0, 32'h00D);
    repeat (300) @(negedge rc_clk);
    rd(0, st);
    chk(st[8] == eh, eh ? "R5 high sticky" : "R7 no high fault", int'(st[8]), int'(eh));
    chk(st[9] == el, el ? "R6 low sticky" : "R7 no low fault", int'(st[9]), int'(el));
    chk(((pul_hi - h0) > 0) == eh, "R5 high pulse seen", pul_hi - h0, int'(eh));
    chk(((pul_lo - l0) > 0) == el, "R6 low pulse seen", pul_lo - l0, int'(el));
    wr(0, 32'h0);
  endtask

  initial begin
    #900000;
    chk(1'b0, "watchdog", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int v, c0, old, res, st, p0, tries;
    void'($urandom(32'd4321));
    repeat (4) @(negedge rc_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge rc_clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      chk(v == 0, "R1 register zero", v, 0);
    end
    chk(!fault_hi_o && !fault_lo_o && !fault_xloss_o, "R1 pulses low",
        int'({fault_hi_o, fault_lo_o, fault_xloss_o}), 0);

    // R2 / R3 directed and random durations, two crystal ratios
    measure(0, "dur0");
    measure(37, "dur37");
    for (int i = 0; i < 4; i++) measure(int'($urandom_range(20, 300)), "rand");
    x_half = 4.0;
    repeat (10) @(negedge rc_clk);
    measure(160, "xtal8ns");
    x_half = 5.0;
    repeat (10) @(negedge rc_clk);

    // R4 restart ignored, result held
    measure(60, "prior");
    rd(4, old);
    wr(3, 100);
    wr(0, 32'h2);
    c0 = cyc;
    repeat (10) @(negedge rc_clk);
    wr(3, 10);
    wr(0, 32'h2);
    rd(4, res);
    chk(res == old, "R4 result held while busy", res, old);
    v = 2;
    while (v[1]) rd(0, v);
    chk((cyc - c0) == 100, "R4 no restart", cyc - c0, 100);
    rd(4, res);
    chk(absdiff(res, 50) <= 2, "R4 R3 result after ignored start", res, 50);

    // R5 R6 R7 directed, then random windows
    window_case(2, 60, 100);
    window_case(1, 60, 100);
    window_case(4, 60, 100);
    tries = 0;
    for (int i = 0; i < 8 && tries < 40; tries++) begin
      int ph, lo, hi, e;
      ph = int'($urandom_range(1, 4));
      lo = int'($urandom_range(20, 120));
      hi = lo + int'($urandom_range(0, 80));
      e  = 160 / ph;
      if ((e > hi + 4) || (e < lo - 4) || (e >= lo + 4 && e <= hi - 4)) begin
        window_case(ph, lo, hi);
        i++;
      end
    end

    // R8 disabled: no faults
    wr(1, 10); wr(2, 5);
    wr(0, 32'h700);
    p_half = 1.0;
    p0 = pul_hi + pul_lo + pul_loss;
    x_run = 1'b0;
    repeat (300) @(negedge rc_clk);
    rd(0, st);
    chk(st[10:8] == 3'b000, "R8 no sticky when off", int'(st[10:8]), 0);
    chk((pul_hi + pul_lo + pul_loss) == p0, "R8 no pulse when off",
        pul_hi + pul_lo + pul_loss - p0, 0);
    x_run = 1'b1;
    repeat (20) @(negedge rc_clk);

    // R9 crystal stall, DIV=2 -> 64 cycles
    wr(1, 32'hFFFFFF); wr(2, 0);
    wr(0, 32'h709);
    repeat (20) @(negedge rc_clk);
    p0 = pul_loss;
    x_run = 1'b0;
    repeat (40) @(negedge rc_clk);
    rd(0, st);
    chk(st[10] == 1'b0, "R9 no loss before timeout", int'(st[10]), 0);
    repeat (60) @(negedge rc_clk);
    rd(0, st);
    chk(st[10] == 1'b1, "R9 loss sticky set", int'(st[10]), 1);
    repeat (100) @(negedge rc_clk);
    chk((pul_loss - p0) == 1, "R9 R11 single loss pulse", pul_loss - p0, 1);

    // R10 write-0 keeps, write-1 clears
    wr(0, 32'h009);
    rd(0, st);
    chk(st[10] == 1'b1, "R10 write zero keeps", int'(st[10]), 1);
    wr(0, 32'h409);
    rd(0, st);
    chk(st[10] == 1'b0, "R10 write one clears", int'(st[10]), 0);
    wr(0, 32'h0);
    x_run = 1'b1;
    repeat (20) @(negedge rc_clk);

    // R11 all pulses one cycle wide
    chk(wide == 0, "R11 pulse width", wide, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule